// File: doc/BRIEF.md
# SD Host Event Status and Interrupt Register Block

This block sits beside an SD/MMC host core and turns the core's event pulses into sticky status bits that software reads over a small byte-wide register port. Each status bit has its own enable bit. A global enable in the block-length control word gates the single level-sensitive interrupt line. Software acknowledges an event by writing a one to its status bit. The block also watches the card-detect and write-protect pins and reports their levels. It raises card-change and card-insertion events from a card-detect source that software picks, with a polarity that software also picks.

The block also holds the transfer geometry that the host core consumes: the block size minus one, the CRC-abort option and the block count. It keeps a read/write clock-control bit, and it reports two busy levels that come from the core. A write to the command byte can soft-reset the block. This clears every status bit, every enable bit and the block-length word. The block count and the clock-control bit keep their values.

Top module: `sd_irq_status`

## Requirements
- R1: After the synchronous reset, every register reads 0x00 while the pins and busy inputs are low, and irq, card_present, blk_count, crc_abort and clk_force_dis are all 0.
- R2: A one-cycle pulse on event_pulse sets its status bit at the next clock edge, and the bit stays set until it is cleared. Index 0 sets status0 bit 4 (multi-block done) and index 1 sets status0 bit 5 (block done). Indexes 2 to 9 set status1 bits 0 to 7 in order: SDIO, command done, response timeout, auto-stop, data timeout, response CRC, read CRC, write CRC.
- R3: Writing to status0 (address 0x0) or status1 (address 0x1) clears each sticky bit whose data bit is 1 and leaves the others unchanged. Writing 0xFF clears the whole byte.
- R4: If an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R5: irq goes high one cycle after a status bit and its enable bit are both 1 while block-length bit 15 is 1. The enable bits are mask0 (0x3) bits 7:4 for status0 bits 7:4, and mask1 (0x4) bits 7:1 for status1 bits 7:1. mask1 bit 0 and mask0 bits 3:0 always read 0, so the SDIO bit never raises irq.
- R6: While block-length bit 15 is 0, irq stays low whatever the status and enable bits hold.
- R7: Block-length bit 14 selects the DAT3 detect pin, and it takes priority over bit 13, which selects the GPI detect pin. With neither bit set, no card is present. Bit 12 set means a high pin signals a card; bit 12 clear means a low pin does. Every change of the detected presence sets status0 bit 6. A change from absent to present also sets status0 bit 7. card_present follows the detected presence.
- R8: status0 bits 1, 2 and 3 read the synchronized write-protect, DAT3 and GPI pin levels. status2 (0x2) bits 4 and 5 read cmd_busy and dat_busy. Writes do not change any of these bits.
- R9: status2 bit 7 is read/write and drives clk_force_dis. The other bits of status2 ignore writes.
- R10: The block-length word is written as a low byte (0x5) and a high byte (0x6). Its bits 10:0 drive blk_size_m1 and bit 11 drives crc_abort. The block count is written as a low byte (0x7) and a high byte (0x8) and drives blk_count. All four bytes read back what was written.
- R11: Writing a value with bit 7 set to the command byte (0x9) clears all status bits, both enable bytes and the block-length word, and card_present goes low. This happens even if an event pulse arrives in the same cycle. blk_count and clk_force_dis keep their values. The command byte reads 0x00.
- R12: reg_rdata shows the register addressed in the previous cycle. Addresses 0xA to 0xF read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| event_pulse | input | 10 | One-cycle event pulses from the host core |
| pin_gpi_cd | input | 1 | GPI card-detect pin (asynchronous) |
| pin_dat3_cd | input | 1 | DAT3 card-detect pin (asynchronous) |
| pin_wp | input | 1 | Write-protect pin (asynchronous) |
| cmd_busy | input | 1 | Command/response busy level from the core |
| dat_busy | input | 1 | Data-response busy level from the core |
| irq | output | 1 | Level interrupt |
| card_present | output | 1 | Detected card presence |
| blk_size_m1 | output | 11 | Block size minus one |
| crc_abort | output | 1 | Abort on CRC error option |
| blk_count | output | 16 | Block count |
| clk_force_dis | output | 1 | Forced-clock disable control |

## Verification
An acknowledge write and a new event can land on the same status bit in the same cycle. The bench provokes this by driving a write of ones to status1 or status0 in the same cycle as an event pulse for one of the bits being cleared, plus a clear of a neighbouring bit. It then expects the pulsed bit to survive and the neighbour to be cleared. The bench also pairs a soft-reset command with an event pulse in a single cycle and expects a status byte of zero. Card-change events raised by a change in the block-length selection fields are checked at the status register in the same way as events raised by pin edges.

// File: rtl/sd_irq_pkg.sv
package sd_irq_pkg;

  // register byte addresses
  localparam int A_EVT0    = 0;
  localparam int A_EVT1    = 1;
  localparam int A_AUX     = 2;
  localparam int A_MSK0    = 3;
  localparam int A_MSK1    = 4;
  localparam int A_BLEN_LO = 5;
  localparam int A_BLEN_HI = 6;
  localparam int A_BCNT_LO = 7;
  localparam int A_BCNT_HI = 8;
  localparam int A_CMD     = 9;

  // event pulse indexes
  localparam int EV_MBLK  = 0;
  localparam int EV_BLK   = 1;
  localparam int EV_SDIO  = 2;
  localparam int EV_LAST  = 9;
  localparam int EVT_W    = EV_LAST + 1;

  localparam int SIZE_W   = 11;
  localparam int BCNT_W   = 16;
  localparam int SOFT_BIT = 7;

  typedef struct packed {
    logic              gie;
    logic              sel_dat3;
    logic              sel_gpi;
    logic              pol_high;
    logic              crc_abort;
    logic [SIZE_W-1:0] size_m1;
  } blen_t;

endpackage

// File: rtl/isc_pin_sync.sv
module isc_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
        end else begin
          chain[0] <= din;
          for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
      end
      assign dout = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/isc_card_detect.sv
module isc_card_detect (
  input  logic clk,
  input  logic rst,
  input  logic sreset,
  input  logic gpi_s,
  input  logic dat3_s,
  input  logic sel_dat3,
  input  logic sel_gpi,
  input  logic pol_high,
  output logic present_q,
  output logic change_evt,
  output logic insert_evt
);
  logic pin_sel;
  logic src_on;
  logic present_now;

  always_comb begin
    pin_sel = 1'b0;
    src_on  = 1'b0;
    if (sel_dat3) begin
      pin_sel = dat3_s;
      src_on  = 1'b1;
    end else if (sel_gpi) begin
      pin_sel = gpi_s;
      src_on  = 1'b1;
    end
    present_now = src_on & (pol_high ? pin_sel : ~pin_sel);
  end

  always_ff @(posedge clk) begin
    if (rst || sreset) present_q <= 1'b0;
    else               present_q <= present_now;
  end

  assign change_evt = present_now ^ present_q;
  assign insert_evt = present_now & ~present_q;
endmodule

// File: rtl/isc_sticky_bank.sv
module isc_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sreset,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst || sreset)  q[b] <= 1'b0;
        else if (set_i[b])  q[b] <= 1'b1;   // event beats acknowledge
        else if (clr_i[b])  q[b] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/isc_irq_gen.sv
module isc_irq_gen #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         gie,
  input  logic [W-1:0] status,
  input  logic [W-1:0] enable,
  output logic         irq_q
);
  logic hit;
  assign hit = gie & (|(status & enable));

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= hit;
  end
endmodule

// File: rtl/sd_irq_status.sv
module sd_irq_status
  import sd_irq_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [EVT_W-1:0]  event_pulse,
  input  logic              pin_gpi_cd,
  input  logic              pin_dat3_cd,
  input  logic              pin_wp,
  input  logic              cmd_busy,
  input  logic              dat_busy,
  output logic              irq,
  output logic              card_present,
  output logic [SIZE_W-1:0] blk_size_m1,
  output logic              crc_abort,
  output logic [BCNT_W-1:0] blk_count,
  output logic              clk_force_dis
);
  localparam int ST1_W = EVT_W - EV_SDIO;
  localparam int ST0_W = 4;
  localparam int IRQ_W = ST1_W + ST0_W;

  // address decode
  logic we_evt0, we_evt1, we_aux, we_msk0, we_msk1;
  logic we_blo, we_bhi, we_clo, we_chi, soft_hit;

  assign we_evt0  = reg_we && (reg_addr == ADDR_W'(A_EVT0));
  assign we_evt1  = reg_we && (reg_addr == ADDR_W'(A_EVT1));
  assign we_aux   = reg_we && (reg_addr == ADDR_W'(A_AUX));
  assign we_msk0  = reg_we && (reg_addr == ADDR_W'(A_MSK0));
  assign we_msk1  = reg_we && (reg_addr == ADDR_W'(A_MSK1));
  assign we_blo   = reg_we && (reg_addr == ADDR_W'(A_BLEN_LO));
  assign we_bhi   = reg_we && (reg_addr == ADDR_W'(A_BLEN_HI));
  assign we_clo   = reg_we && (reg_addr == ADDR_W'(A_BCNT_LO));
  assign we_chi   = reg_we && (reg_addr == ADDR_W'(A_BCNT_HI));
  assign soft_hit = reg_we && (reg_addr == ADDR_W'(A_CMD)) && reg_wdata[SOFT_BIT];

  // control registers
  blen_t             blen_q;
  logic [15:0]       blen_bits;
  logic [BCNT_W-1:0] bcnt_q;
  logic [7:4]        msk0_q;
  logic [7:1]        msk1_q;
  logic              aux7_q;

  assign blen_bits = blen_q;

  always_ff @(posedge clk) begin
    if (rst || soft_hit) begin
      blen_q <= '0;
      msk0_q <= '0;
      msk1_q <= '0;
    end else begin
      if (we_blo)  blen_q <= blen_t'({blen_bits[15:8], reg_wdata});
      if (we_bhi)  blen_q <= blen_t'({reg_wdata, blen_bits[7:0]});
      if (we_msk0) msk0_q <= reg_wdata[7:4];
      if (we_msk1) msk1_q <= reg_wdata[7:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt_q <= '0;
      aux7_q <= 1'b0;
    end else begin
      if (we_clo) bcnt_q[7:0]  <= reg_wdata;
      if (we_chi) bcnt_q[15:8] <= reg_wdata;
      if (we_aux) aux7_q       <= reg_wdata[7];
    end
  end

  // pin synchronizers
  logic [2:0] pins_s;
  logic       gpi_s, dat3_s, wp_s;

  isc_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({pin_gpi_cd, pin_dat3_cd, pin_wp}),
    .dout (pins_s)
  );
  assign {gpi_s, dat3_s, wp_s} = pins_s;

  // card detect
  logic cd_present, cd_change, cd_insert;

  isc_card_detect u_cd (
    .clk        (clk),
    .rst        (rst),
    .sreset     (soft_hit),
    .gpi_s      (gpi_s),
    .dat3_s     (dat3_s),
    .sel_dat3   (blen_q.sel_dat3),
    .sel_gpi    (blen_q.sel_gpi),
    .pol_high   (blen_q.pol_high),
    .present_q  (cd_present),
    .change_evt (cd_change),
    .insert_evt (cd_insert)
  );

  // sticky status
  logic [ST0_W-1:0] st0_q;   // status0 bits 7:4
  logic [ST1_W-1:0] st1_q;   // status1 bits 7:0

  isc_sticky_bank #(.W(ST0_W)) u_st0 (
    .clk    (clk),
    .rst    (rst),
    .sreset (soft_hit),
    .set_i  ({cd_insert, cd_change, event_pulse[EV_BLK], event_pulse[EV_MBLK]}),
    .clr_i  (we_evt0 ? reg_wdata[7:4] : '0),
    .q      (st0_q)
  );

  isc_sticky_bank #(.W(ST1_W)) u_st1 (
    .clk    (clk),
    .rst    (rst),
    .sreset (soft_hit),
    .set_i  (event_pulse[EV_LAST:EV_SDIO]),
    .clr_i  (we_evt1 ? reg_wdata : '0),
    .q      (st1_q)
  );

  // interrupt
  isc_irq_gen #(.W(IRQ_W)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .gie    (blen_q.gie),
    .status ({st1_q, st0_q}),
    .enable ({msk1_q, 1'b0, msk0_q}),
    .irq_q  (irq)
  );

  // read path
  logic [7:0] rd_mux;

  always_comb begin
    rd_mux = 8'h00;
    if (reg_addr == ADDR_W'(A_EVT0))         rd_mux = {st0_q, gpi_s, dat3_s, wp_s, 1'b0};
    else if (reg_addr == ADDR_W'(A_EVT1))    rd_mux = st1_q;
    else if (reg_addr == ADDR_W'(A_AUX))     rd_mux = {aux7_q, 1'b0, dat_busy, cmd_busy, 4'h0};
    else if (reg_addr == ADDR_W'(A_MSK0))    rd_mux = {msk0_q, 4'h0};
    else if (reg_addr == ADDR_W'(A_MSK1))    rd_mux = {msk1_q, 1'b0};
    else if (reg_addr == ADDR_W'(A_BLEN_LO)) rd_mux = blen_bits[7:0];
    else if (reg_addr == ADDR_W'(A_BLEN_HI)) rd_mux = blen_bits[15:8];
    else if (reg_addr == ADDR_W'(A_BCNT_LO)) rd_mux = bcnt_q[7:0];
    else if (reg_addr == ADDR_W'(A_BCNT_HI)) rd_mux = bcnt_q[15:8];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= 8'h00;
    else     reg_rdata <= rd_mux;
  end

  assign card_present  = cd_present;
  assign blk_size_m1   = blen_q.size_m1;
  assign crc_abort     = blen_q.crc_abort;
  assign blk_count     = bcnt_q;
  assign clk_force_dis = aux7_q;
endmodule

// File: rtl/sd_irq_status_chk.sv
module sd_irq_status_chk
  import sd_irq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic [EVT_W-1:0]  event_pulse,
  input logic              cmd_busy,
  input logic              dat_busy,
  input logic              irq,
  input logic              card_present,
  input logic [3:0]        st0_q,
  input logic [7:0]        st1_q,
  input logic [7:4]        msk0_q,
  input logic [7:1]        msk1_q,
  input logic [15:0]       blen_bits
);
  logic       soft_hit;
  logic [7:0] ev1;
  logic [1:0] ev0;
  logic       any_en;

  assign soft_hit = reg_we && (reg_addr == ADDR_W'(A_CMD)) && reg_wdata[SOFT_BIT];
  assign ev1      = event_pulse[EV_LAST:EV_SDIO];
  assign ev0      = {event_pulse[EV_BLK], event_pulse[EV_MBLK]};
  assign any_en   = blen_bits[15] && (|({st1_q[7:1], st0_q} & {msk1_q, msk0_q}));

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (!soft_hit) |=> (((st1_q & $past(ev1)) == $past(ev1)) &&
                     ((st0_q[1:0] & $past(ev0)) == $past(ev0))));   // R2 R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == ADDR_W'(A_EVT1)) |=>
      ((st1_q & $past(reg_wdata & ~ev1)) == 8'h00));                // R3

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(any_en)));                               // R5

  AST_CD_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!soft_hit) |=> ((card_present == $past(card_present)) || st0_q[2])); // R7

  AST_BUSY_VIEW: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(A_AUX)) |=>
      (reg_rdata[5:4] == $past({dat_busy, cmd_busy})));             // R8

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_hit |=> (st0_q == 4'h0 && st1_q == 8'h00 && msk0_q == 4'h0 &&
                  msk1_q == 7'h00 && blen_bits == 16'h0000));        // R11

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr > ADDR_W'(A_CMD)) |=> (reg_rdata == 8'h00));          // R12
endmodule

bind sd_irq_status sd_irq_status_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .reg_we       (reg_we),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .event_pulse  (event_pulse),
  .cmd_busy     (cmd_busy),
  .dat_busy     (dat_busy),
  .irq          (irq),
  .card_present (card_present),
  .st0_q        (st0_q),
  .st1_q        (st1_q),
  .msk0_q       (msk0_q),
  .msk1_q       (msk1_q),
  .blen_bits    (blen_bits)
);

// File: tb/sd_irq_status_tb_top.sv
module sd_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [9:0]  event_pulse = '0;
  logic        pin_gpi_cd = 1'b0, pin_dat3_cd = 1'b0, pin_wp = 1'b0;
  logic        cmd_busy = 1'b0, dat_busy = 1'b0;
  logic        irq, card_present, crc_abort, clk_force_dis;
  logic [10:0] blk_size_m1;
  logic [15:0] blk_count;

  always #5 clk = ~clk;

  sd_irq_status dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_pulse(event_pulse),
    .pin_gpi_cd(pin_gpi_cd), .pin_dat3_cd(pin_dat3_cd), .pin_wp(pin_wp),
    .cmd_busy(cmd_busy), .dat_busy(dat_busy), .irq(irq),
    .card_present(card_present), .blk_size_m1(blk_size_m1),
    .crc_abort(crc_abort), .blk_count(blk_count), .clk_force_dis(clk_force_dis)
  );

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic rdf = 1'b0;
  logic rdf_q = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) rdf_q <= rdf;

  // monitor: compare registered read data against the scoreboard queue
  always @(negedge clk) begin
    if (rdf_q) begin
      exp_t e;
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard underflow act=%h exp=none", reg_rdata);
      end else begin
        e = q.pop_front();
        if (reg_rdata !== e.exp) begin
          n_bad++;
          $display("FAIL %s act=%h exp=%h", e.tag, reg_rdata, e.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string t);
    exp_t x;
    x.exp = e; x.tag = t;
    q.push_back(x);
    reg_addr = a; rdf = 1'b1;
    @(negedge clk);
    rdf = 1'b0;
  endtask

  task automatic pulse(int idx);
    event_pulse = '0;
    event_pulse[idx] = 1'b1;
    @(negedge clk);
    event_pulse = '0;
  endtask

  task automatic chk(logic [15:0] act, logic [15:0] e, string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", t, act, e);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 9; a++) rd(4'(a), 8'h00, "R1 reset register");
    chk(16'(irq), 16'h0, "R1 irq");
    chk(blk_count, 16'h0, "R1 blk_count");
    chk(16'(clk_force_dis), 16'h0, "R1 clk_force_dis");
    chk(16'(card_present), 16'h0, "R1 card_present");
    chk(16'(crc_abort), 16'h0, "R1 crc_abort");

    // R12 unmapped and command byte
    rd(4'hA, 8'h00, "R12 unmapped 0xA");
    rd(4'hF, 8'h00, "R12 unmapped 0xF");
    rd(4'h9, 8'h00, "R12 command byte");

    // R10 geometry
    wr(4'h5, 8'hFF);
    wr(4'h6, 8'h0B);
    chk(16'(blk_size_m1), 16'h03FF, "R10 blk_size_m1");
    chk(16'(crc_abort), 16'h1, "R10 crc_abort");
    rd(4'h5, 8'hFF, "R10 blen lo");
    rd(4'h6, 8'h0B, "R10 blen hi");
    wr(4'h7, 8'h34);
    wr(4'h8, 8'h12);
    chk(blk_count, 16'h1234, "R10 blk_count");
    rd(4'h7, 8'h34, "R10 bcnt lo");
    rd(4'h8, 8'h12, "R10 bcnt hi");
    wr(4'h6, 8'h00);
    chk(16'(crc_abort), 16'h0, "R10 crc_abort off");

    // R2 each event sets its bit
    for (int i = 0; i < 10; i++) begin
      pulse(i);
      if (i < 2) begin
        rd(4'h0, 8'h10 << i, "R2 status0 event");
        wr(4'h0, 8'hFF);
      end else begin
        rd(4'h1, 8'h01 << (i - 2), "R2 status1 event");
        wr(4'h1, 8'hFF);
      end
    end
    pulse(3);
    idle(5);
    rd(4'h1, 8'h02, "R2 sticky hold");

    // R3 write-one-to-clear
    pulse(4);
    wr(4'h1, 8'h02);
    rd(4'h1, 8'h04, "R3 partial clear");
    wr(4'h1, 8'h00);
    rd(4'h1, 8'h04, "R3 zero write");
    wr(4'h1, 8'hFF);
    rd(4'h1, 8'h00, "R3 full clear");
    pulse(0);
    pulse(1);
    wr(4'h0, 8'h10);
    rd(4'h0, 8'h20, "R3 status0 partial");
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h00, "R3 status0 full");

    // R8 level bits
    pin_wp = 1'b1; pin_gpi_cd = 1'b1; pin_dat3_cd = 1'b1;
    idle(4);
    rd(4'h0, 8'h0E, "R8 pin levels");
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h0E, "R8 levels ignore write");
    cmd_busy = 1'b1;
    rd(4'h2, 8'h10, "R8 cmd busy");
    cmd_busy = 1'b0; dat_busy = 1'b1;
    rd(4'h2, 8'h20, "R8 data busy");
    dat_busy = 1'b0;
    pin_wp = 1'b0; pin_gpi_cd = 1'b0; pin_dat3_cd = 1'b0;
    idle(4);

    // R9 clock control bit
    wr(4'h2, 8'h80);
    chk(16'(clk_force_dis), 16'h1, "R9 clk_force_dis set");
    rd(4'h2, 8'h80, "R9 aux readback");
    wr(4'h2, 8'h30);
    rd(4'h2, 8'h00, "R9 busy bits not writable");
    chk(16'(clk_force_dis), 16'h0, "R9 clk_force_dis clear");
    wr(4'h2, 8'h80);

    // R4 event wins over same-cycle clear
    pulse(3);
    pulse(4);
    reg_we = 1'b1; reg_addr = 4'h1; reg_wdata = 8'h06; event_pulse[3] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; event_pulse = '0;
    rd(4'h1, 8'h02, "R4 status1 collision");
    wr(4'h1, 8'hFF);
    pulse(1);
    reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h20; event_pulse[1] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; event_pulse = '0;
    rd(4'h0, 8'h20, "R4 status0 collision");
    wr(4'h0, 8'hFF);

    // R5 R6 interrupt
    wr(4'h4, 8'hFF);
    rd(4'h4, 8'hFE, "R5 mask1 bit0 reserved");
    wr(4'h3, 8'hFF);
    rd(4'h3, 8'hF0, "R5 mask0 low bits reserved");
    pulse(3);
    idle(1);
    chk(16'(irq), 16'h0, "R6 gie off");
    wr(4'h6, 8'h80);
    idle(1);
    chk(16'(irq), 16'h1, "R5 irq on gie");
    wr(4'h1, 8'h02);
    idle(1);
    chk(16'(irq), 16'h0, "R5 irq after ack");
    pulse(2);
    idle(1);
    chk(16'(irq), 16'h0, "R5 sdio never interrupts");
    wr(4'h1, 8'hFF);
    wr(4'h4, 8'h00);
    pulse(9);
    idle(1);
    chk(16'(irq), 16'h0, "R5 masked event");
    wr(4'h4, 8'h80);
    idle(1);
    chk(16'(irq), 16'h1, "R5 late unmask");
    wr(4'h1, 8'hFF);
    idle(1);
    chk(16'(irq), 16'h0, "R5 cleared");
    pulse(0);
    idle(1);
    chk(16'(irq), 16'h1, "R5 status0 source");
    wr(4'h0, 8'hFF);
    idle(1);
    chk(16'(irq), 16'h0, "R5 status0 cleared");
    wr(4'h6, 8'h00);

    // R7 card detect
    wr(4'h6, 8'h30);
    idle(4);
    rd(4'h0, 8'h00, "R7 gpi high-active idle");
    pin_gpi_cd = 1'b1;
    idle(5);
    rd(4'h0, 8'hC8, "R7 insertion");
    chk(16'(card_present), 16'h1, "R7 present");
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h08, "R7 acked");
    pin_gpi_cd = 1'b0;
    idle(5);
    rd(4'h0, 8'h40, "R7 removal");
    chk(16'(card_present), 16'h0, "R7 absent");
    wr(4'h0, 8'hFF);
    wr(4'h6, 8'h20);
    idle(3);
    rd(4'h0, 8'hC0, "R7 active-low polarity");
    chk(16'(card_present), 16'h1, "R7 present low pin");
    wr(4'h0, 8'hFF);
    wr(4'h6, 8'h60);
    idle(3);
    rd(4'h0, 8'h00, "R7 dat3 selected no change");
    pin_dat3_cd = 1'b1;
    idle(5);
    rd(4'h0, 8'h44, "R7 dat3 priority");
    chk(16'(card_present), 16'h0, "R7 dat3 absent");
    wr(4'h0, 8'hFF);
    rd(4'h0, 8'h04, "R7 dat3 acked");
    wr(4'h6, 8'hE0);
    pin_dat3_cd = 1'b0;
    idle(5);
    chk(16'(irq), 16'h1, "R7 insertion interrupt");
    wr(4'h0, 8'hFF);
    idle(1);
    chk(16'(irq), 16'h0, "R7 insertion acked");

    // R11 soft reset
    pulse(3);
    reg_we = 1'b1; reg_addr = 4'h9; reg_wdata = 8'h80; event_pulse[4] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; event_pulse = '0;
    rd(4'h1, 8'h00, "R11 status cleared");
    rd(4'h3, 8'h00, "R11 mask0 cleared");
    rd(4'h4, 8'h00, "R11 mask1 cleared");
    rd(4'h6, 8'h00, "R11 blen hi cleared");
    rd(4'h5, 8'h00, "R11 blen lo cleared");
    rd(4'h7, 8'h34, "R11 bcnt kept");
    rd(4'h2, 8'h80, "R11 aux kept");
    rd(4'h0, 8'h00, "R11 status0 cleared");
    chk(16'(clk_force_dis), 16'h1, "R11 clk_force_dis kept");
    chk(16'(card_present), 16'h0, "R11 card_present low");
    chk(16'(irq), 16'h0, "R11 irq low");
    wr(4'h4, 8'h02);
    wr(4'h9, 8'h7F);
    rd(4'h4, 8'h02, "R11 no reset without bit7");

    idle(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule